// File: doc/BRIEF.md
# Text Display Fetch Sequencer

This block paces a character-mapped raster display. It keeps three counters: the character position across a text line, the scan row within a character cell, and the text line on the screen. From these counters it forms storage read addresses. Each read returns two bytes, which are held in a data register. The block then hands the code of the character under the beam to a glyph generator.

Each pulse of `adv` is one character time. The screen has 16 text lines of 64 characters, and each character cell is 12 scan rows tall. After the last character of a frame, the block runs a set number of blank retrace counts. It then starts again at the upper-left corner.

There are three display modes:
- **Normal:** shows stored bytes as characters.
- **Hex-dump:** shows each byte as two hex digits stacked on two consecutive screen lines.
- **Half-width:** shows 32 characters, taken from the left or right half of a storage line, with a blank cell between neighbouring characters.

Top module: `txt_fetch_seq`

## Requirements
- R1: After reset, all counters are zero. `frame_start` is 1, `row` is 0, `retrace` and `code_valid` are 0, and the first `adv` pulse asserts `fetch` with `addr` 0.
- R2: In normal mode (`mode`=00 or 11), `fetch` asserts on every `adv` pulse whose character count is even. `addr` is then line*64 + character count.
- R3: In normal mode, the cycle after an `adv` pulse, `code` shows a byte of the pair fetched at `addr`. An even count selects `rd_data[7:0]` (the byte at `addr`) and an odd count selects `rd_data[15:8]`. `code_valid` is 1 in that cycle.
- R4: After character count 63, the count returns to 0, `row` increments, and the next fetch address goes back to the base of the same line.
- R5: After row 11, `row` returns to 0, the line count increments, and the base address advances by 64.
- R6: `frame_end` is 1 at line 15, row 11, character 63. The next `RETRACE` pulses of `adv` give `retrace`=1, no `fetch` and no `code_valid`. Then the counters restart at zero with `frame_start`=1.
- R7: In hex-dump mode (`mode`=01), the code is `GLYPH_BASE` + upper nibble on even line counts (odd-numbered screen lines). It is `GLYPH_BASE` + lower nibble on odd line counts.
- R8: In hex-dump mode, the base address is (line count / 2)*64, so it advances only after each odd line count.
- R9: In half-width mode (`mode`=10), `fetch` asserts only when character count mod 4 is 0. `addr` is then base + 32*`half_right` + count/2.
- R10: In half-width mode, odd counts give code `BLANK`. Count mod 4 = 0 selects `rd_data[7:0]` and count mod 4 = 2 selects `rd_data[15:8]`.
- R11: While `adv` is low, `fetch` is 0, `row` and all counters hold, and `code_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | One character time elapses |
| mode | input | 2 | 00/11 normal, 01 hex-dump, 10 half-width |
| half_right | input | 1 | Half-width: 1 selects the right 32 characters |
| rd_data | input | 16 | Byte pair read at `addr` (low byte is the even byte) |
| addr | output | AW | Storage read address |
| fetch | output | 1 | Storage read strobe for this character time |
| code | output | 8 | Character code for the glyph generator |
| code_valid | output | 1 | `code` is for the previous character time |
| row | output | 4 | Scan row within the character cell |
| frame_start | output | 1 | Position is the upper-left corner |
| frame_end | output | 1 | Position is the last character of the frame |
| retrace | output | 1 | Blank retrace interval |

## Verification
The bench drives `adv` with periodic gaps and checks every character time against a model of its own. It runs a whole normal frame, so the wrap at character 63, row 11 and line 15 is hit in sequence. A design that wrapped one count late would fetch address 64 on line 0. A design that forgot to rewind to the line base on a row change would walk through storage.

In hex-dump mode, a base that advanced on every line would show the wrong bytes from line 1 onward. Swapped nibble polarity would show the lower digit first. In half-width mode, the right-half offset and the fetch-every-fourth-count cadence are both checked. A wrong cadence would shift the character order or drop the blank columns.

// File: rtl/txt_fetch_seq.sv
module txt_fetch_seq #(
  parameter int CHARS      = 64,
  parameter int ROWS       = 12,
  parameter int LINES      = 16,
  parameter int RETRACE    = 100,
  parameter int AW         = 10,
  parameter logic [7:0] GLYPH_BASE = 8'h30,
  parameter logic [7:0] BLANK      = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic          half_right,
  input  logic [15:0]   rd_data,
  output logic [AW-1:0] addr,
  output logic          fetch,
  output logic [7:0]    code,
  output logic          code_valid,
  output logic [3:0]    row,
  output logic          frame_start,
  output logic          frame_end,
  output logic          retrace
);
  localparam int CW = $clog2(CHARS);
  localparam int RW = $clog2(ROWS);
  localparam int LW = $clog2(LINES);
  localparam int TW = $clog2(RETRACE + 1);

  logic [CW-1:0] ch;
  logic [RW-1:0] rw;
  logic [LW-1:0] ln;
  logic [TW-1:0] rt;
  logic          in_rt;
  logic [15:0]   dreg;

  wire hex  = (mode == 2'b01);
  wire half = (mode == 2'b10);

  wire last_ch = (ch == CW'(CHARS - 1));
  wire last_rw = (rw == RW'(ROWS - 1));
  wire last_ln = (ln == LW'(LINES - 1));

  wire [LW-1:0] eline = hex ? (ln >> 1) : ln;
  wire [AW-1:0] base  = AW'(eline) * AW'(CHARS);
  wire [AW-1:0] hoff  = half_right ? AW'(CHARS / 2) : '0;

  assign addr  = half ? base + hoff + AW'(ch >> 1) : base + AW'(ch);
  assign fetch = adv && !in_rt && (half ? (ch[1:0] == 2'b00) : !ch[0]);

  wire [15:0] pair = fetch ? rd_data : dreg;
  wire        hi   = half ? ch[1] : ch[0];
  wire [7:0]  byt  = hi ? pair[15:8] : pair[7:0];
  wire [3:0]  nib  = ln[0] ? byt[3:0] : byt[7:4];
  wire [7:0]  nxt_code = (half && ch[0]) ? BLANK :
                         hex ? GLYPH_BASE + {4'b0, nib} : byt;

  assign row         = 4'(rw);
  assign retrace     = in_rt;
  assign frame_start = !in_rt && ch == '0 && rw == '0 && ln == '0;
  assign frame_end   = !in_rt && last_ch && last_rw && last_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch <= '0; rw <= '0; ln <= '0; rt <= '0; in_rt <= 1'b0;
      dreg <= '0; code <= '0; code_valid <= 1'b0;
    end else begin
      code_valid <= adv && !in_rt;
      if (adv) begin
        if (fetch) dreg <= rd_data;
        if (!in_rt) code <= nxt_code;
        if (in_rt) begin
          if (rt == TW'(RETRACE - 1)) begin
            rt <= '0;
            in_rt <= 1'b0;
          end else
            rt <= rt + 1'b1;
        end else if (last_ch) begin
          ch <= '0;
          if (last_rw) begin
            rw <= '0;
            if (last_ln) begin
              ln <= '0;
              in_rt <= 1'b1;
            end else
              ln <= ln + 1'b1;
          end else
            rw <= rw + 1'b1;
        end else
          ch <= ch + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txt_fetch_seq_chk.sv
module txt_fetch_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adv,
  input logic       fetch,
  input logic       retrace,
  input logic [3:0] row,
  input logic       frame_start,
  input logic       frame_end,
  input logic       code_valid
);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row) && !code_valid);
  // R11
  fetch_needs_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> adv);
  // R6
  retrace_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrace |-> !fetch);
  // R6
  end_to_retrace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && frame_end) |=> retrace);
  // R1
  start_not_retrace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !retrace && row == 4'd0);
  // R3
  valid_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(adv));
endmodule

bind txt_fetch_seq txt_fetch_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .fetch(fetch), .retrace(retrace),
  .row(row), .frame_start(frame_start), .frame_end(frame_end),
  .code_valid(code_valid)
);

// File: tb/tb_txt_fetch_seq.sv
module tb_txt_fetch_seq;
  localparam int PERIOD = 10;
  localparam int RET = 100;
  localparam logic [7:0] GB = 8'h30;
  localparam logic [7:0] BL = 8'h20;

  logic clk = 0, rst_n = 0, adv = 0, half_right = 0;
  logic [1:0] mode = 0;
  logic [15:0] rd_data;
  logic [9:0] addr;
  logic fetch, code_valid, frame_start, frame_end, retrace;
  logic [7:0] code;
  logic [3:0] row;

  int vectors = 0, miscompares = 0;
  int c, r, l, rt, in_rt;
  logic [7:0] expq[$];
  string ctag[$];

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memf(input logic [9:0] a);
    logic [7:0] lo;
    lo = a[7:0] ^ {a[9:8], a[9:8], a[9:8], a[9:8]};
    return {lo + 8'h37, lo};
  endfunction

  assign rd_data = memf(addr);

  txt_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode(mode), .half_right(half_right),
    .rd_data(rd_data), .addr(addr), .fetch(fetch), .code(code),
    .code_valid(code_valid), .row(row), .frame_start(frame_start),
    .frame_end(frame_end), .retrace(retrace)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (c=%0d r=%0d l=%0d)", tag, act, exp, c, r, l);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && code_valid) begin
      if (expq.size() == 0) chk("R11 unexpected code_valid", 1, 0);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = ctag.pop_front();
        chk(t, code, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    adv = 0; rst_n = 0;
    c = 0; r = 0; l = 0; rt = 0; in_rt = 0;
    expq.delete(); ctag.delete();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 frame_start", frame_start, 1);
    chk("R1 row", row, 0);
    chk("R1 retrace", retrace, 0);
    chk("R1 code_valid", code_valid, 0);
  endtask

  task automatic tick(input bit a);
    int base, eline, pa, ef, ea;
    bit hi;
    logic [15:0] pr;
    logic [7:0] b, ec;
    string ta, tc;
    @(negedge clk);
    adv = a;
    #1;
    if (!a) begin
      chk("R11 fetch idle", fetch, 0);
      chk("R11 row hold", row, r);
      return;
    end
    if (in_rt) begin
      chk("R6 retrace", retrace, 1);
      chk("R6 no fetch", fetch, 0);
      rt++;
      if (rt == RET) begin in_rt = 0; rt = 0; end
      return;
    end
    ta = (mode == 2'b10) ? "R9" : (mode == 2'b01) ? "R8" : "R2";
    tc = (mode == 2'b10) ? "R10" : (mode == 2'b01) ? "R7" : "R3";
    eline = (mode == 2'b01) ? l / 2 : l;
    base = eline * 64;
    if (mode == 2'b10) begin
      ef = (c % 4 == 0);
      ea = base + (half_right ? 32 : 0) + c / 2;
      pa = base + (half_right ? 32 : 0) + (c / 4) * 2;
      hi = (c % 4 == 2);
    end else begin
      ef = (c % 2 == 0);
      ea = base + c;
      pa = base + (c / 2) * 2;
      hi = (c % 2 == 1);
    end
    chk({ta, " fetch"}, fetch, ef);
    if (ef) chk({ta, (c == 0) ? " R4 addr at line base" : " addr"}, addr, ea);
    chk("R6 retrace low", retrace, 0);
    chk((r == 0 && c == 0) ? "R5 row" : "R4 row", row, r);
    chk("R1 frame_start", frame_start, (c == 0 && r == 0 && l == 0));
    chk("R6 frame_end", frame_end, (c == 63 && r == 11 && l == 15));
    pr = memf(10'(pa));
    b = hi ? pr[15:8] : pr[7:0];
    if (mode == 2'b10 && c % 2 == 1) ec = BL;
    else if (mode == 2'b01) ec = GB + {4'b0, (l % 2 == 0) ? b[7:4] : b[3:0]};
    else ec = b;
    expq.push_back(ec);
    ctag.push_back(tc);
    c++;
    if (c == 64) begin
      c = 0; r++;
      if (r == 12) begin
        r = 0; l++;
        if (l == 16) begin l = 0; in_rt = 1; rt = 0; end
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick((i % 7) != 6);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mode = 2'b00; half_right = 0;
    do_reset();
    run(15000);
    mode = 2'b01;
    do_reset();
    run(14500);
    mode = 2'b10; half_right = 0;
    do_reset();
    run(3000);
    mode = 2'b10; half_right = 1;
    do_reset();
    run(3000);
    mode = 2'b11;
    do_reset();
    run(1000);
    @(negedge clk); adv = 0;
    @(negedge clk); @(negedge clk);
    chk("R3 scoreboard drained", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule